// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a clock by a programmable ratio N = P×B + A, the way a frequency synthesizer's feedback path does. A prescaler switches between moduli P+1 and P. A swallow count A sets how many prescaler cycles use the longer modulus. A main count B sets the total number of prescaler cycles in one output period. The prescaler is plain counting logic running on the block clock. An optional halving stage ahead of it makes the prescaler advance on every second clock only.

Software-facing logic outside this block presents A, B, a two-bit prescaler code and a halving select as static inputs. A synchronous counter-reset input holds the counters at their load values. Inputs that change while the divider runs are picked up at the end of the current output period, never part way through one. An error output reports a configuration whose main count is smaller than its swallow count.

Top module: `dualModDivider`

## Requirements
- R1: `divPulse` goes high for exactly one clock once every N = P×B + A prescaler input ticks. With the halving stage off, one tick is one clock.
- R2: `pscSel` selects P: code 0 gives 8, code 1 gives 16, code 2 gives 32, and code 3 also gives 32.
- R3: The full swallow range 0 to 31 of the 5-bit `swallowIn` is honoured in the ratio.
- R4: `mainIn` is 13 bits wide. Values 0, 1 and 2 are raised to 3 before use, so the smallest main count is 3.
- R5: With `halfSel` = 1 the prescaler advances on every second clock, so pulses are 2N clocks apart.
- R6: While `cntRst` is 1, no pulse is produced and all counters stay at their load values. After release, the first pulse appears N clocks later (2N with halving on).
- R7: `cfgErr` is 1 one clock after `mainIn` < `swallowIn` holds on the inputs, and 0 one clock after it does not.
- R8: Changes to `swallowIn`, `mainIn`, `pscSel` or `halfSel` while running leave the current period at its old ratio. The new ratio applies from the following period.
- R9: Within a period, all prescaler cycles of modulus P+1 come before the cycles of modulus P. Once the swallow phase has ended, it does not restart before the next reload.
- R10: While `rstN` is low, `divPulse` and `cfgErr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| cntRst | input | 1 | Synchronous hold of all counters at their load values |
| swallowIn | input | 5 | Swallow count A |
| mainIn | input | 13 | Main count B |
| pscSel | input | 2 | Prescaler modulus code |
| halfSel | input | 1 | Halving stage select |
| divPulse | output | 1 | One-clock pulse per divided period |
| cfgErr | output | 1 | Main count below swallow count |

## Verification
The pulse is registered. A release of `cntRst` at one falling edge therefore gives its first pulse at the N-th falling edge after it (the 2N-th with halving). Each later pulse comes exactly N or 2N falling edges after the previous one. The bench counts falling edges from the release and compares both the first gap and the second gap against P×B + A, which it computes from the requirements. `cfgErr` lags the inputs by one register, so it is sampled one falling edge after the inputs change. For the mid-period change, the new inputs are applied five clocks into a period, and the bench expects the old ratio for that gap and the new ratio for the gap after it.

// File: rtl/divPkg.sv
package divPkg;
  localparam int SWALLOW_W = 5;
  localparam int MAIN_W    = 13;
  localparam int MAIN_MIN  = 3;
  localparam int PSC_W     = 6;

  // strobes issued by the control section to the datapath
  typedef struct packed {
    logic tick;     // prescaler input advances this clock
    logic pscWrap;  // prescaler finishes one modulus cycle
    logic reload;   // output period ends: reload counters
    logic load;     // hold counters at load state
  } divStrobeT;

  // datapath status back to control
  typedef struct packed {
    logic swallowActive;  // swallow count not yet exhausted
    logic mainLast;       // main counter on its final prescaler cycle
  } divStatusT;

  function automatic logic [PSC_W-1:0] pscModulus(input logic [1:0] code);
    logic [PSC_W-1:0] m;
    case (code)
      2'd0:    m = PSC_W'(8);
      2'd1:    m = PSC_W'(16);
      default: m = PSC_W'(32);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int PW = PSC_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cntRst,
  input  logic [1:0] pscSel,
  input  logic      halfSel,
  input  divStatusT status,
  output divStrobeT stb
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] pscCnt;
  logic [PW-1:0] baseMod;
  logic [PW-1:0] modNow;
  logic [1:0]    pscQ;
  logic          halfQ;
  logic          halfTgl;
  logic          primeQ;
  logic          tick;
  logic          pscWrap;
  logic          loadNow;

  always_comb begin
    loadNow = cntRst || !primeQ;
    baseMod = PW'(pscModulus(pscQ));
    modNow  = status.swallowActive ? baseMod + ONE : baseMod;
    tick    = halfQ ? halfTgl : 1'b1;
    pscWrap = tick && (pscCnt == modNow - ONE);
    stb.tick    = tick;
    stb.pscWrap = pscWrap;
    stb.load    = loadNow;
    stb.reload  = pscWrap && status.mainLast && !loadNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt  <= '0;
      pscQ    <= 2'd0;
      halfQ   <= 1'b0;
      halfTgl <= 1'b0;
      primeQ  <= 1'b0;
    end else begin
      primeQ <= 1'b1;
      if (loadNow) begin
        pscCnt  <= '0;
        halfTgl <= 1'b0;
        pscQ    <= pscSel;
        halfQ   <= halfSel;
      end else begin
        halfTgl <= ~halfTgl;
        if (tick) begin
          pscCnt <= pscWrap ? '0 : pscCnt + ONE;
        end
        if (stb.reload) begin
          pscQ  <= pscSel;
          halfQ <= halfSel;
        end
      end
    end
  end
endmodule

// File: rtl/divData.sv
module divData
  import divPkg::*;
#(
  parameter int AW   = SWALLOW_W,
  parameter int BW   = MAIN_W,
  parameter int BMIN = MAIN_MIN
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] swallowIn,
  input  logic [BW-1:0] mainIn,
  input  divStrobeT     stb,
  output divStatusT     status,
  output logic          divPulse,
  output logic          cfgErr
);
  localparam logic [BW-1:0] B_FLOOR = BW'(BMIN);
  localparam logic [BW-1:0] B_ONE   = BW'(1);
  localparam logic [AW-1:0] A_ONE   = AW'(1);

  logic [AW-1:0] swCnt;
  logic [BW-1:0] mainCnt;
  logic [BW-1:0] mainEff;

  always_comb begin
    mainEff              = (mainIn < B_FLOOR) ? B_FLOOR : mainIn;
    status.swallowActive = (swCnt != '0);
    status.mainLast      = (mainCnt == B_ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swCnt    <= '0;
      mainCnt  <= B_FLOOR;
      divPulse <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      cfgErr   <= (mainIn < BW'(swallowIn));
      divPulse <= stb.reload;
      if (stb.load || stb.reload) begin
        swCnt   <= swallowIn;
        mainCnt <= mainEff;
      end else if (stb.pscWrap) begin
        if (swCnt != '0) swCnt <= swCnt - A_ONE;
        mainCnt <= mainCnt - B_ONE;
      end
    end
  end
endmodule

// File: rtl/dualModDivider.sv
module dualModDivider
  import divPkg::*;
#(
  parameter int AW   = SWALLOW_W,
  parameter int BW   = MAIN_W,
  parameter int BMIN = MAIN_MIN,
  parameter int PW   = PSC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntRst,
  input  logic [AW-1:0] swallowIn,
  input  logic [BW-1:0] mainIn,
  input  logic [1:0]    pscSel,
  input  logic          halfSel,
  output logic          divPulse,
  output logic          cfgErr
);
  divStrobeT stb;
  divStatusT status;

  divCtrl #(.PW(PW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cntRst (cntRst),
    .pscSel (pscSel),
    .halfSel(halfSel),
    .status (status),
    .stb    (stb)
  );

  divData #(.AW(AW), .BW(BW), .BMIN(BMIN)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .swallowIn(swallowIn),
    .mainIn   (mainIn),
    .stb      (stb),
    .status   (status),
    .divPulse (divPulse),
    .cfgErr   (cfgErr)
  );
endmodule

// File: rtl/divChk.sv
module divChk
  import divPkg::*;
#(
  parameter int AW = SWALLOW_W,
  parameter int BW = MAIN_W
) (
  input logic          clk,
  input logic          rstN,
  input logic          cntRst,
  input logic [AW-1:0] swallowIn,
  input logic [BW-1:0] mainIn,
  input logic          divPulse,
  input logic          cfgErr,
  input divStrobeT     stb,
  input divStatusT     status
);
  // R1
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R6
  hold_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntRst |=> !divPulse);

  // R7
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cfgErr == ($past(mainIn) < BW'($past(swallowIn)))));

  // R9
  swallow_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!status.swallowActive && !stb.reload && !stb.load) |=> !status.swallowActive);

  // R10
  always_comb begin
    if (!rstN) begin
      reset_out_chk: assert (!divPulse && !cfgErr);
    end
  end
endmodule

bind dualModDivider divChk #(.AW(AW), .BW(BW)) u_divChk (
  .clk      (clk),
  .rstN     (rstN),
  .cntRst   (cntRst),
  .swallowIn(swallowIn),
  .mainIn   (mainIn),
  .divPulse (divPulse),
  .cfgErr   (cfgErr),
  .stb      (stb),
  .status   (status)
);

// File: tb/test_dualModDivider.sv
module test_dualModDivider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntRst = 1'b1;
  logic [4:0]  swallowIn = '0;
  logic [12:0] mainIn = 13'd3;
  logic [1:0]  pscSel = 2'd0;
  logic        halfSel = 1'b0;
  logic        divPulse;
  logic        cfgErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dualModDivider i_dualModDivider (
    .clk(clk), .rstN(rstN), .cntRst(cntRst), .swallowIn(swallowIn),
    .mainIn(mainIn), .pscSel(pscSel), .halfSel(halfSel),
    .divPulse(divPulse), .cfgErr(cfgErr)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic configure(input int a, input int b, input int p, input bit h);
    @(negedge clk);
    cntRst = 1'b1;
    swallowIn = 5'(a);
    mainIn = 13'(b);
    pscSel = 2'(p);
    halfSel = h;
    @(negedge clk);
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!divPulse && n < 20000);
  endtask

  task automatic measure(output int first, output int second);
    cntRst = 1'b0;
    waitPulse(first);
    waitPulse(second);
  endtask

  task automatic runRatio(input string tag, input int a, input int b, input int p,
                          input bit h, input int exp);
    int f, s;
    configure(a, b, p, h);
    measure(f, s);
    checkEq({tag, " first gap"}, f, exp);
    checkEq({tag, " second gap"}, s, exp);
  endtask

  task automatic tReset;
    // R10: outputs low under reset
    checkEq("R10 divPulse in reset", int'(divPulse), 0);
    checkEq("R10 cfgErr in reset", int'(cfgErr), 0);
  endtask

  task automatic tHold;
    int seen = 0;
    int f, s;
    configure(3, 5, 0, 1'b0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (divPulse) seen++;
    end
    checkEq("R6 pulses while held", seen, 0);
    cntRst = 1'b0;
    repeat (10) @(negedge clk);
    cntRst = 1'b1;
    repeat (3) @(negedge clk);
    measure(f, s);
    checkEq("R6 first gap after mid-period hold", f, 43);
  endtask

  task automatic tCfgErr;
    @(negedge clk);
    swallowIn = 5'd6;
    mainIn = 13'd4;
    @(negedge clk);
    checkEq("R7 cfgErr with B<A", int'(cfgErr), 1);
    swallowIn = 5'd2;
    @(negedge clk);
    checkEq("R7 cfgErr with B>=A", int'(cfgErr), 0);
    swallowIn = 5'd4;
    @(negedge clk);
    checkEq("R7 cfgErr with B==A", int'(cfgErr), 0);
  endtask

  task automatic tChange;
    int n = 0;
    int s;
    configure(0, 3, 0, 1'b0);
    cntRst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      n++;
    end
    swallowIn = 5'd3;
    mainIn = 13'd5;
    while (!divPulse && n < 20000) begin
      @(negedge clk);
      n++;
    end
    checkEq("R8 period running during change keeps old ratio", n, 24);
    waitPulse(s);
    checkEq("R8 next period uses new ratio", s, 43);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runRatio("R1 P=8 B=3 A=0", 0, 3, 0, 1'b0, 24);
    runRatio("R1 R9 P=8 B=5 A=3", 3, 5, 0, 1'b0, 43);
    runRatio("R2 R3 code1 B=40 A=31", 31, 40, 1, 1'b0, 671);
    runRatio("R2 code2 B=3 A=2", 2, 3, 2, 1'b0, 98);
    runRatio("R2 code3 B=3 A=2", 2, 3, 3, 1'b0, 98);
    runRatio("R4 B=1 raised to 3", 0, 1, 0, 1'b0, 24);
    runRatio("R4 B=0 raised to 3", 0, 0, 0, 1'b0, 24);
    runRatio("R4 R1 code2 B=300 A=31", 31, 300, 2, 1'b0, 9631);
    runRatio("R5 halved B=4 A=1", 1, 4, 0, 1'b1, 66);
    tHold();
    tCfgErr();
    tChange();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule